// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit datapath. Each cycle it takes an operation code, two byte operands and the current status byte. It returns a byte result and a new status byte in which only the flags owned by the chosen operation are rewritten. All other status bits pass through untouched. The carry-in and the zero flag used for chained arithmetic are read from the incoming status byte.

It covers addition and subtraction with and without carry, AND/OR/XOR, one's and two's complement, increment, decrement, shifts, rotates through carry, nibble exchange, and compares that set flags but leave the result equal to operand A. The results are computed in one combinational stage and registered once, so outputs appear on the clock edge after the inputs are presented. The register file, immediate handling and word-wide arithmetic belong to the surrounding pipeline.

Top module: `alu8_core`

## Requirements
- R1: While rst_n is low, result_o and flags_o read 0x00. After reset, the outputs for the inputs sampled at one rising edge are visible right after that edge.
- R2: Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5. Bits 7:6 pass through unchanged for every operation. Every operation except swap and unused codes sets S to N XOR V. N is always result bit 7.
- R3: ADD (code 0) gives A+B and ADC (code 1) gives A+B+C. Both update Z, C, N, V, S and H. C is the carry out of bit 7, H is the carry out of bit 3, and V is signed overflow.
- R4: SUB (code 2) gives A-B and SBC (code 3) gives A-B-C. Both update all six flags. C is the borrow out of bit 7, H is the borrow out of bit 3, and V is signed overflow.
- R5: For SBC and CMPC, Z ends at 1 only when the 8-bit difference is zero and the incoming Z is 1. SUB and CMP set Z from the difference alone.
- R6: CMP (code 17) computes A-B and CMPC (code 18) computes A-B-C. Their flags follow R4 and R5, and result_o equals operand A.
- R7: AND (4), OR (5) and XOR (6) update Z, N, S and clear V. C and H keep their incoming values.
- R8: COM (7) gives 0xFF-A, sets C to 1, clears V and keeps H. NEG (8) gives 0x00-A, with all six flags as for subtracting A from zero.
- R9: INC (9) and DEC (10) give A+1 and A-1 with wraparound. V is set exactly when A was 0x7F (INC) or 0x80 (DEC). C and H are kept.
- R10: LSL (11) shifts left with 0 into bit 0, and ROL (13) shifts left with C into bit 0. Both set C from old bit 7, H from old bit 3, and V to N XOR C.
- R11: LSR (12) puts 0 in bit 7, ROR (14) puts C in bit 7, and ASR (15) keeps bit 7. All three shift right, set C from old bit 0, set V to N XOR C, and keep H.
- R12: SWAP (16) exchanges bits 3:0 with bits 7:4 and leaves all eight status bits unchanged.
- R13: Any code from 19 to 31 returns operand A and leaves the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| opa_i | input | 8 | Operand A (destination value) |
| opb_i | input | 8 | Operand B (source value) |
| flags_i | input | 8 | Current status byte, source of carry-in and chaining Z |
| result_o | output | 8 | Registered result |
| flags_o | output | 8 | Registered updated status byte |

## Verification
In a subtract-with-carry or compare-with-carry, the borrow-in and the zero chaining from the incoming status byte act in the same cycle. Both the borrow and the Z outcome depend on the incoming flags as well as on the operands. The bench drives these operations with all four combinations of incoming C and Z, including operand pairs whose difference is exactly zero or exactly one, and checks both flags together against an independent integer model. Increment at 0x7F, decrement at 0x80, and a negate of 0x80 give a second collision, where overflow and the sign of the result are produced together.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int FLAG_W = 8;
    localparam int UPD_W  = 6;

    localparam int F_C = 0;
    localparam int F_Z = 1;
    localparam int F_N = 2;
    localparam int F_V = 3;
    localparam int F_S = 4;
    localparam int F_H = 5;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_COM  = 5'd7,
        OP_NEG  = 5'd8,
        OP_INC  = 5'd9,
        OP_DEC  = 5'd10,
        OP_LSL  = 5'd11,
        OP_LSR  = 5'd12,
        OP_ROL  = 5'd13,
        OP_ROR  = 5'd14,
        OP_ASR  = 5'd15,
        OP_SWAP = 5'd16,
        OP_CMP  = 5'd17,
        OP_CMPC = 5'd18
    } alu_op_e;

    // update masks, one bit per flag position 0..5
    localparam logic [UPD_W-1:0] UPD_ALL   = 6'b111111;
    localparam logic [UPD_W-1:0] UPD_ZNVS  = 6'b011110;
    localparam logic [UPD_W-1:0] UPD_ZCNVS = 6'b011111;
    localparam logic [UPD_W-1:0] UPD_NONE  = 6'b000000;

    // Rewrite only the flags selected by upd; S always follows N xor V.
    function automatic logic [FLAG_W-1:0] merge_flags(
        input logic [FLAG_W-1:0] old,
        input logic [UPD_W-1:0]  upd,
        input logic              z,
        input logic              c,
        input logic              n,
        input logic              v,
        input logic              h
    );
        logic [FLAG_W-1:0] nf;
        nf = old;
        if (upd[F_C]) nf[F_C] = c;
        if (upd[F_Z]) nf[F_Z] = z;
        if (upd[F_N]) nf[F_N] = n;
        if (upd[F_V]) nf[F_V] = v;
        if (upd[F_S]) nf[F_S] = n ^ v;
        if (upd[F_H]) nf[F_H] = h;
        return nf;
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e           op,
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [W-1:0]      res,
    output logic [FLAG_W-1:0] flags_out
);
    localparam int LO = W / 2;

    logic [W-1:0]  x, y, r;
    logic          cin, sub, chain, v, z;
    logic [W:0]    full;
    logic [LO:0]   low;

    always_comb begin
        x     = a;
        y     = b;
        cin   = 1'b0;
        sub   = 1'b0;
        chain = 1'b0;
        case (op)
            OP_ADC:         cin = flags_in[F_C];
            OP_SUB, OP_CMP: sub = 1'b1;
            OP_SBC, OP_CMPC: begin
                sub   = 1'b1;
                cin   = flags_in[F_C];
                chain = 1'b1;
            end
            OP_NEG: begin
                x   = '0;
                y   = a;
                sub = 1'b1;
            end
            default: ;
        endcase

        if (sub) begin
            full = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, cin};
            low  = {1'b0, x[LO-1:0]} - {1'b0, y[LO-1:0]} - {{LO{1'b0}}, cin};
        end else begin
            full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
            low  = {1'b0, x[LO-1:0]} + {1'b0, y[LO-1:0]} + {{LO{1'b0}}, cin};
        end
        r = full[W-1:0];

        if (sub)
            v = (x[W-1] & ~y[W-1] & ~r[W-1]) | (~x[W-1] & y[W-1] & r[W-1]);
        else
            v = (x[W-1] & y[W-1] & ~r[W-1]) | (~x[W-1] & ~y[W-1] & r[W-1]);

        z = (r == '0) & (chain ? flags_in[F_Z] : 1'b1);

        res = ((op == OP_CMP) || (op == OP_CMPC)) ? a : r;
        flags_out = merge_flags(flags_in, UPD_ALL, z, full[W], r[W-1], v, low[LO]);
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e           op,
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [W-1:0]      res,
    output logic [FLAG_W-1:0] flags_out
);
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0]      r;
    logic              v;
    logic [UPD_W-1:0]  upd;

    always_comb begin
        r   = a;
        v   = 1'b0;
        upd = UPD_ZNVS;
        case (op)
            OP_AND: r = a & b;
            OP_OR:  r = a | b;
            OP_XOR: r = a ^ b;
            OP_COM: begin
                r   = ~a;
                upd = UPD_ZCNVS;
            end
            OP_INC: begin
                r = a + ONE;
                v = (r == MIN_NEG);
            end
            OP_DEC: begin
                r = a - ONE;
                v = (r == MAX_POS);
            end
            default: upd = UPD_NONE;
        endcase
        res       = r;
        flags_out = merge_flags(flags_in, upd, (r == '0), 1'b1, r[W-1], v, 1'b0);
    end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e           op,
    input  logic [W-1:0]      a,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [W-1:0]      res,
    output logic [FLAG_W-1:0] flags_out
);
    localparam int LO = W / 2;

    logic [W-1:0]      r;
    logic              c;
    logic [UPD_W-1:0]  upd;

    always_comb begin
        r   = a;
        c   = 1'b0;
        upd = UPD_ZCNVS;
        case (op)
            OP_LSL: begin
                r   = {a[W-2:0], 1'b0};
                c   = a[W-1];
                upd = UPD_ALL;
            end
            OP_ROL: begin
                r   = {a[W-2:0], flags_in[F_C]};
                c   = a[W-1];
                upd = UPD_ALL;
            end
            OP_LSR: begin
                r = {1'b0, a[W-1:1]};
                c = a[0];
            end
            OP_ROR: begin
                r = {flags_in[F_C], a[W-1:1]};
                c = a[0];
            end
            OP_ASR: begin
                r = {a[W-1], a[W-1:1]};
                c = a[0];
            end
            OP_SWAP: begin
                r   = {a[LO-1:0], a[W-1:LO]};
                upd = UPD_NONE;
            end
            default: upd = UPD_NONE;
        endcase
        res       = r;
        flags_out = merge_flags(flags_in, upd, (r == '0), c, r[W-1],
                                r[W-1] ^ c, a[LO-1]);
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        op_i,
    input  logic [W-1:0]      opa_i,
    input  logic [W-1:0]      opb_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [W-1:0]      result_o,
    output logic [FLAG_W-1:0] flags_o
);
    typedef struct packed {
        logic [W-1:0]      res;
        logic [FLAG_W-1:0] flags;
    } alu_state_t;

    alu_op_e           op;
    logic [W-1:0]      ar_res, lg_res, sh_res;
    logic [FLAG_W-1:0] ar_flg, lg_flg, sh_flg;
    alu_state_t        st_d, st_q;

    assign op = alu_op_e'(op_i);

    alu8_arith #(.W(W)) u_arith (
        .op(op), .a(opa_i), .b(opb_i), .flags_in(flags_i),
        .res(ar_res), .flags_out(ar_flg)
    );

    alu8_logic #(.W(W)) u_logic (
        .op(op), .a(opa_i), .b(opb_i), .flags_in(flags_i),
        .res(lg_res), .flags_out(lg_flg)
    );

    alu8_shift #(.W(W)) u_shift (
        .op(op), .a(opa_i), .flags_in(flags_i),
        .res(sh_res), .flags_out(sh_flg)
    );

    always_comb begin
        st_d.res   = opa_i;
        st_d.flags = flags_i;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_CMP, OP_CMPC: begin
                st_d.res   = ar_res;
                st_d.flags = ar_flg;
            end
            OP_AND, OP_OR, OP_XOR, OP_COM, OP_INC, OP_DEC: begin
                st_d.res   = lg_res;
                st_d.flags = lg_flg;
            end
            OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR, OP_SWAP: begin
                st_d.res   = sh_res;
                st_d.flags = sh_flg;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o = st_q.res;
    assign flags_o  = st_q.flags;

endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        op_i,
    input logic [W-1:0]      opa_i,
    input logic [FLAG_W-1:0] flags_i,
    input logic [W-1:0]      result_o,
    input logic [FLAG_W-1:0] flags_o
);
    localparam int LO = W / 2;

    // set once an edge with reset released has registered real inputs
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_upper_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> flags_o[7:6] == $past(flags_i[7:6]));

    assert_sign_rule_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(op_i) <= 5'd18 && $past(op_i) != 5'd16
        |-> flags_o[F_S] == (flags_o[F_N] ^ flags_o[F_V]));

    assert_chain_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && ($past(op_i) == 5'd3 || $past(op_i) == 5'd18) && !$past(flags_i[F_Z])
        |-> !flags_o[F_Z]);

    assert_cmp_keeps_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && ($past(op_i) == 5'd17 || $past(op_i) == 5'd18)
        |-> result_o == $past(opa_i));

    assert_logic_keeps_ch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && ($past(op_i) == 5'd4 || $past(op_i) == 5'd5 || $past(op_i) == 5'd6)
        |-> !flags_o[F_V] && flags_o[F_C] == $past(flags_i[F_C])
            && flags_o[F_H] == $past(flags_i[F_H]));

    assert_swap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(op_i) == 5'd16
        |-> flags_o == $past(flags_i)
            && result_o == {$past(opa_i[LO-1:0]), $past(opa_i[W-1:LO])});

    assert_unused_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(op_i) > 5'd18
        |-> flags_o == $past(flags_i) && result_o == $past(opa_i));

endmodule

bind alu8_core alu8_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .opa_i(opa_i), .flags_i(flags_i),
    .result_o(result_o), .flags_o(flags_o)
);

// File: tb/sim_alu8_core.sv
module sim_alu8_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_i = 5'd0;
    logic [7:0] opa_i = 8'h05;
    logic [7:0] opb_i = 8'h06;
    logic [7:0] flags_i = 8'h00;
    logic [7:0] result_o, flags_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int         res;
        logic [7:0] flg;
        logic [4:0] op;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    alu8_core u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
        .flags_i(flags_i), .result_o(result_o), .flags_o(flags_o)
    );

    function automatic string req_of(input logic [4:0] op);
        case (op)
            5'd0, 5'd1:         return "R3";
            5'd2:               return "R4";
            5'd3:               return "R4/R5";
            5'd4, 5'd5, 5'd6:   return "R7";
            5'd7, 5'd8:         return "R8";
            5'd9, 5'd10:        return "R9";
            5'd11, 5'd13:       return "R10";
            5'd12, 5'd14, 5'd15: return "R11";
            5'd16:              return "R12";
            5'd17, 5'd18:       return "R6";
            default:            return "R13";
        endcase
    endfunction

    function automatic int sx(input int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    // independent integer reference
    function automatic exp_t model(input logic [4:0] op, input int a, input int b,
                                   input logic [7:0] f);
        exp_t e;
        int r, x, y, ci, d, sd;
        bit c, z, v, h, set_c, set_h, set_v, set_zns, chain;
        c = f[0]; h = f[5]; v = f[3];
        set_c = 0; set_h = 0; set_v = 0; set_zns = 0; chain = 0;
        r = a;
        ci = f[0];
        case (op)
            5'd0, 5'd1: begin
                x = a; y = b; if (op == 5'd0) ci = 0;
                d = x + y + ci; r = d & 255; c = d > 255;
                h = ((x & 15) + (y & 15) + ci) > 15;
                sd = sx(x) + sx(y) + ci; v = (sd > 127) || (sd < -128);
                set_c = 1; set_h = 1; set_v = 1; set_zns = 1;
            end
            5'd2, 5'd3, 5'd8, 5'd17, 5'd18: begin
                x = a; y = b;
                if (op == 5'd2 || op == 5'd17) ci = 0;
                if (op == 5'd8) begin x = 0; y = a; ci = 0; end
                chain = (op == 5'd3) || (op == 5'd18);
                d = x - y - ci; r = d & 255; c = d < 0;
                h = ((x & 15) - (y & 15) - ci) < 0;
                sd = sx(x) - sx(y) - ci; v = (sd > 127) || (sd < -128);
                set_c = 1; set_h = 1; set_v = 1; set_zns = 1;
            end
            5'd4, 5'd5, 5'd6: begin
                r = (op == 5'd4) ? (a & b) : (op == 5'd5) ? (a | b) : (a ^ b);
                v = 0; set_v = 1; set_zns = 1;
            end
            5'd7: begin
                r = 255 - a; c = 1; v = 0; set_c = 1; set_v = 1; set_zns = 1;
            end
            5'd9:  begin r = (a + 1) & 255; v = (a == 127); set_v = 1; set_zns = 1; end
            5'd10: begin r = (a + 255) & 255; v = (a == 128); set_v = 1; set_zns = 1; end
            5'd11, 5'd13: begin
                r = ((a * 2) & 255) | ((op == 5'd13) ? int'(f[0]) : 0);
                c = (a >= 128); h = (a >> 3) & 1;
                v = (r >= 128) ^ c;
                set_c = 1; set_h = 1; set_v = 1; set_zns = 1;
            end
            5'd12, 5'd14, 5'd15: begin
                r = a >> 1;
                if (op == 5'd14) r = r | (int'(f[0]) * 128);
                if (op == 5'd15) r = r | (a & 128);
                c = a & 1; v = (r >= 128) ^ c;
                set_c = 1; set_v = 1; set_zns = 1;
            end
            5'd16: r = ((a & 15) * 16) | (a / 16);
            default: r = a;
        endcase
        e.flg = f;
        if (set_zns) begin
            z = (r == 0) && (!chain || f[1]);
            e.flg[1] = z;
            e.flg[2] = (r >= 128);
            e.flg[3] = set_v ? v : f[3];
            e.flg[4] = e.flg[2] ^ e.flg[3];
        end
        if (set_c) e.flg[0] = c;
        if (set_h) e.flg[5] = h;
        e.res = ((op == 5'd17) || (op == 5'd18)) ? a : r;
        e.op = op;
        return e;
    endfunction

    task automatic drive(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] f);
        @(negedge clk);
        op_i = op; opa_i = a; opb_i = b; flags_i = f;
        sb_q.push_back(model(op, int'(a), int'(b), f));
    endtask

    // monitor: compare registered outputs shortly after each edge
    always @(posedge clk) begin
        #2;
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (int'(result_o) != e.res || flags_o != e.flg) begin
                errors++;
                $display("FAIL %s op=%0d result=%02h flags=%02h expected result=%02h flags=%02h",
                         req_of(e.op), e.op, result_o, flags_o, e.res[7:0], e.flg);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: outputs held at zero under reset despite live inputs
        flags_i = 8'hFF; opa_i = 8'hA5;
        repeat (3) @(negedge clk);
        checks++;
        if (result_o !== 8'h00 || flags_o !== 8'h00) begin
            errors++;
            $display("FAIL R1 result=%02h flags=%02h expected result=00 flags=00",
                     result_o, flags_o);
        end
        rst_n = 1'b1;

        // R3 half carry, overflow, carry with zero
        drive(5'd0, 8'h0F, 8'h01, 8'h00);
        drive(5'd0, 8'h7F, 8'h01, 8'h00);
        drive(5'd0, 8'hFF, 8'h01, 8'h00);
        drive(5'd1, 8'hFE, 8'h01, 8'h01);
        // R4 borrow cases
        drive(5'd2, 8'h10, 8'h01, 8'h00);
        drive(5'd2, 8'h80, 8'h01, 8'h00);
        // R5 chaining: all C/Z combinations on zero and one differences
        for (int cz = 0; cz < 4; cz++) begin
            drive(5'd3,  8'h42, 8'h42, {6'b0, cz[1], cz[0]});
            drive(5'd3,  8'h43, 8'h42, {6'b0, cz[1], cz[0]});
            drive(5'd18, 8'h42, 8'h42, {6'b0, cz[1], cz[0]});
            drive(5'd18, 8'h43, 8'h42, {6'b0, cz[1], cz[0]});
        end
        // R6 compare leaves operand A
        drive(5'd17, 8'h05, 8'h09, 8'hC0);
        // R7 logic keeps C and H
        drive(5'd4, 8'hF0, 8'h0F, 8'h29);
        drive(5'd6, 8'h80, 8'h01, 8'h08);
        // R8 complement and negate edges
        drive(5'd7, 8'hFF, 8'h00, 8'h20);
        drive(5'd8, 8'h80, 8'h00, 8'h00);
        drive(5'd8, 8'h00, 8'h00, 8'h01);
        // R9 overflow boundaries
        drive(5'd9,  8'h7F, 8'h00, 8'h21);
        drive(5'd10, 8'h80, 8'h00, 8'h21);
        drive(5'd9,  8'hFF, 8'h00, 8'h00);
        // R10 / R11 shifts and rotates through carry
        drive(5'd11, 8'h88, 8'h00, 8'h00);
        drive(5'd13, 8'h40, 8'h00, 8'h01);
        drive(5'd12, 8'h01, 8'h00, 8'h20);
        drive(5'd14, 8'h02, 8'h00, 8'h01);
        drive(5'd15, 8'h81, 8'h00, 8'h00);
        // R12 swap keeps every flag
        drive(5'd16, 8'h3C, 8'h00, 8'hFF);
        // R13 unused codes
        drive(5'd25, 8'h5A, 8'h11, 8'h97);
        drive(5'd31, 8'h00, 8'hFF, 8'h40);
        // R2 random sweep including status bits 7:6
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] rop;
            rop = 5'($urandom_range(0, 20));
            drive(rop, 8'($urandom), 8'($urandom), 8'($urandom));
        end
        repeat (3) @(posedge clk);
        #3;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule